// File: doc/BRIEF.md
# Status Register Auto-Polling Matcher

This block drives a serial command engine so that it reads a device status register over and over. Each read returns one to four status bytes. The block zeroes the unused upper bytes, masks the rest and compares them with a reference value. The compare uses one of two rules. In all-bits mode, every unmasked bit must equal its reference bit. In any-bit mode, it is enough that one unmasked bit equals its reference bit. Between reads the block leaves a programmable idle gap, counted in clock cycles.

On a hit the block sets a sticky match flag. This flag can drive an interrupt line. If stop-on-hit is enabled, polling ends and the block returns to idle. If it is disabled, polling continues until an abort, and the last status captured stays visible on an output. An abort given during the idle gap ends polling at once. An abort given while a read is pending ends polling when that read's response arrives. Every end of polling sets a done flag.

The serial shifting is not part of this block. The command engine appears as a request held high until a one-cycle acknowledge that carries the received status word.

Top module: `status_poll_matcher`

## Requirements
- R1: After reset the block is idle: `busy`, `cmd_req`, `match_flag`, `xfer_done` and `irq` are 0 and `status_value` is 0.
- R2: A `start` pulse while idle raises `cmd_req` and `busy` on the next cycle and clears `xfer_done`. `cmd_req` stays high until a cycle with `cmd_ack` high.
- R3: `cfg_size` selects how many status bytes take part: code 0 means bits 7:0, 1 means bits 15:0, 2 means bits 23:0 and 3 means all 32 bits. Bits above the selected bytes are ignored in the compare and read as 0 in `status_value`.
- R4: With `cfg_or_mode` = 0, a read is a hit when `(data ^ cfg_match) & cfg_mask` is zero over the selected bytes. An empty effective mask is therefore always a hit.
- R5: With `cfg_or_mode` = 1, a read is a hit when at least one bit of the selected bytes has its `cfg_mask` bit set and equals its `cfg_match` bit. An empty effective mask is never a hit.
- R6: After an acknowledged read that does not end polling, `cmd_req` stays low for exactly `cfg_interval` cycles before the next request. With an interval of 0, `cmd_req` stays high.
- R7: With `cfg_auto_stop` = 1, a hit returns the block to idle on the next cycle and sets `xfer_done`.
- R8: With `cfg_auto_stop` = 0, polling continues after a hit, and `status_value` is updated on every acknowledged read.
- R9: `match_flag` is set by a hit and stays set until a cycle with `flag_clear` high and no hit. A hit in the same cycle as a clear wins.
- R10: `irq` is high exactly when `match_flag` and `irq_en` are both high.
- R11: `abort` during the inter-read gap returns the block to idle on the next cycle and sets `xfer_done`.
- R12: `abort` while a read is pending lets that read complete, then returns the block to idle and sets `xfer_done`.
- R13: `abort` while the block is idle has no effect: `busy` and `xfer_done` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mask | input | 32 | Bit mask applied to the received status |
| cfg_match | input | 32 | Reference value for the compare |
| cfg_interval | input | 16 | Idle cycles between two reads |
| cfg_size | input | 2 | Number of status bytes minus one |
| cfg_or_mode | input | 1 | 0: all unmasked bits must match; 1: any one unmasked bit |
| cfg_auto_stop | input | 1 | Stop polling on the first hit |
| irq_en | input | 1 | Interrupt enable for the match flag |
| start | input | 1 | Begin polling (idle only) |
| abort | input | 1 | End polling |
| flag_clear | input | 1 | Clear the match flag |
| cmd_req | output | 1 | Status read request to the command engine |
| cmd_ack | input | 1 | One-cycle response strobe from the command engine |
| cmd_data | input | 32 | Received status word, byte 0 in bits 7:0 |
| busy | output | 1 | Polling in progress |
| status_value | output | 32 | Last received status, unused bytes zeroed |
| match_flag | output | 1 | Sticky hit flag |
| xfer_done | output | 1 | Polling has ended |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the request handshake, the absence of a request while idle, the gap after an acknowledge when the interval is non-zero, and the stop on a hit. They also check the clear of the flag, the interrupt gating and the immediate abort during the gap. Only the bench scenarios can show the following: the exact compare result for random masks, sizes and modes; the exact length of the gap; the deferred abort and the idle abort; and the continued updates of the captured status in non-stop mode.

// File: rtl/status_poll_matcher.sv
module status_poll_matcher #(
  parameter int BYTES = 4,
  parameter int IVL_W = 16,
  localparam int DW = 8 * BYTES,
  localparam int SW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    cfg_mask,
  input  logic [DW-1:0]    cfg_match,
  input  logic [IVL_W-1:0] cfg_interval,
  input  logic [SW-1:0]    cfg_size,
  input  logic             cfg_or_mode,
  input  logic             cfg_auto_stop,
  input  logic             irq_en,
  input  logic             start,
  input  logic             abort,
  input  logic             flag_clear,
  output logic             cmd_req,
  input  logic             cmd_ack,
  input  logic [DW-1:0]    cmd_data,
  output logic             busy,
  output logic [DW-1:0]    status_value,
  output logic             match_flag,
  output logic             xfer_done,
  output logic             irq
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WAIT} st_t;

  st_t              st;
  logic [IVL_W-1:0] gap_cnt;
  logic             abort_pend;
  logic [DW-1:0]    lane_mask, eff_mask, diff;
  logic             hit, got, stop_now;

  always_comb begin
    for (int b = 0; b < BYTES; b++)
      lane_mask[8*b +: 8] = (b <= int'(cfg_size)) ? 8'hFF : 8'h00;
  end

  assign eff_mask = cfg_mask & lane_mask;
  assign diff     = cmd_data ^ cfg_match;
  assign hit      = cfg_or_mode ? |(~diff & eff_mask) : ~|(diff & eff_mask);
  assign got      = (st == S_READ) && cmd_ack;
  assign stop_now = (hit && cfg_auto_stop) || abort || abort_pend;

  assign cmd_req = (st == S_READ);
  assign busy    = (st != S_IDLE);
  assign irq     = match_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      gap_cnt      <= '0;
      abort_pend   <= 1'b0;
      status_value <= '0;
      xfer_done    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st         <= S_READ;
          xfer_done  <= 1'b0;
          abort_pend <= 1'b0;
        end
        S_READ: begin
          if (abort) abort_pend <= 1'b1;
          if (got) begin
            status_value <= cmd_data & lane_mask;
            if (stop_now) begin
              st         <= S_IDLE;
              xfer_done  <= 1'b1;
              abort_pend <= 1'b0;
            end else if (cfg_interval != '0) begin
              st      <= S_WAIT;
              gap_cnt <= cfg_interval;
            end
          end
        end
        S_WAIT: begin
          if (abort) begin
            st        <= S_IDLE;
            xfer_done <= 1'b1;
          end else if (gap_cnt == IVL_W'(1)) begin
            st <= S_READ;
          end else begin
            gap_cnt <= gap_cnt - IVL_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               match_flag <= 1'b0;
    else if (got && hit)      match_flag <= 1'b1;
    else if (flag_clear)      match_flag <= 1'b0;
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack |=> cmd_req);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_req);

  // R6
  gap_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && cmd_ack && (cfg_interval != '0) |=> !cmd_req);

  // R7
  auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && cmd_ack && cfg_auto_stop && hit |=> !busy && match_flag && xfer_done);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clear && !(cmd_req && cmd_ack) |=> !match_flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (match_flag && irq_en));

  // R11
  abort_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_req && abort |=> !busy && xfer_done);

endmodule

// File: tb/status_poll_matcher_test.sv
module status_poll_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_mask = '0, cfg_match = '0, cmd_data = '0;
  logic [15:0] cfg_interval = '0;
  logic [1:0]  cfg_size = '0;
  logic        cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1, irq_en = 1'b0;
  logic        start = 1'b0, abort = 1'b0, flag_clear = 1'b0, cmd_ack = 1'b0;
  logic        cmd_req, busy, match_flag, xfer_done, irq;
  logic [31:0] status_value;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  status_poll_matcher uut (
    .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_match(cfg_match),
    .cfg_interval(cfg_interval), .cfg_size(cfg_size), .cfg_or_mode(cfg_or_mode),
    .cfg_auto_stop(cfg_auto_stop), .irq_en(irq_en), .start(start), .abort(abort),
    .flag_clear(flag_clear), .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_data(cmd_data),
    .busy(busy), .status_value(status_value), .match_flag(match_flag),
    .xfer_done(xfer_done), .irq(irq));

  function automatic logic [31:0] size_bits(input logic [1:0] s);
    size_bits = (s == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (s + 1))) - 1);
  endfunction

  function automatic bit exp_hit(input logic [31:0] d, m, ref_v, input logic [1:0] s,
                                 input bit orm);
    logic [31:0] em;
    bit r;
    em = m & size_bits(s);
    r = orm ? 1'b0 : 1'b1;
    for (int i = 0; i < 32; i++)
      if (em[i]) begin
        if (orm && d[i] == ref_v[i]) r = 1'b1;
        if (!orm && d[i] != ref_v[i]) r = 1'b0;
      end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] d, input int dly, input bit clr);
    while (!cmd_req) @(negedge clk);
    repeat (dly) @(negedge clk);
    cmd_ack = 1'b1; cmd_data = d; flag_clear = clr;
    @(negedge clk);
    cmd_ack = 1'b0; flag_clear = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clear = 1'b1; @(negedge clk); flag_clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 req", cmd_req, 0);
    check("R1 flag", match_flag, 0);
    check("R1 done", xfer_done, 0);
    check("R1 status", status_value, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 abort while idle
    abort = 1'b1; @(negedge clk); abort = 1'b0; @(negedge clk);
    check("R13 busy", busy, 0);
    check("R13 done", xfer_done, 0);

    // R2 start / hold
    cfg_mask = 32'hFF; cfg_match = 32'h01; cfg_size = 0; cfg_or_mode = 0; cfg_auto_stop = 1;
    pulse_start();
    check("R2 req", cmd_req, 1);
    check("R2 busy", busy, 1);
    repeat (3) @(negedge clk);
    check("R2 hold", cmd_req, 1);
    // R3 upper bytes ignored; R7 stop on hit
    do_read(32'hABCD_EF01, 0, 0);
    check("R3 status", status_value, 32'h0000_0001);
    check("R7 busy", busy, 0);
    check("R7 done", xfer_done, 1);
    check("R9 set", match_flag, 1);
    // R10 irq gating
    check("R10 off", irq, 0);
    irq_en = 1'b1; #1;
    check("R10 on", irq, 1);
    clear_flag();
    check("R9 clear", match_flag, 0);
    check("R10 after clear", irq, 0);
    irq_en = 1'b0;

    // R4 empty mask hits, R5 empty mask misses
    cfg_mask = 32'h0; cfg_or_mode = 0;
    pulse_start();
    check("R2 done cleared", xfer_done, 0);
    do_read(32'h1234_5678, 1, 0);
    check("R4 empty", match_flag, 1);
    clear_flag();
    cfg_or_mode = 1;
    pulse_start();
    do_read(32'h1234_5678, 0, 0);
    check("R5 empty", match_flag, 0);
    check("R5 still busy", busy, 1);
    // R12 abort while read pending
    while (!cmd_req) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    check("R12 waits", busy, 1);
    do_read(32'h0, 2, 0);
    check("R12 busy", busy, 0);
    check("R12 done", xfer_done, 1);

    // R6 interval, R8 non-stop, R11 abort in gap
    cfg_mask = 32'hFFFF; cfg_match = 32'h00AA; cfg_size = 1; cfg_or_mode = 0;
    cfg_auto_stop = 0; cfg_interval = 16'd3;
    pulse_start();
    do_read(32'h7700_00AA, 0, 0);
    check("R8 flag", match_flag, 1);
    check("R8 status", status_value, 32'h0000_00AA);
    begin
      int n = 0;
      while (!cmd_req && n < 100) begin n++; @(negedge clk); end
      check("R6 gap3", n, 3);
    end
    // R9 hit beats clear in same cycle
    do_read(32'h0000_00AA, 0, 1);
    check("R9 priority", match_flag, 1);
    cfg_interval = 16'd0;
    while (!cmd_req) @(negedge clk);
    do_read(32'h0000_1234, 0, 0);
    check("R8 update", status_value, 32'h0000_1234);
    check("R6 gap0", cmd_req, 1);
    check("R8 busy", busy, 1);
    cfg_interval = 16'd5;
    do_read(32'h0000_1234, 0, 0);
    @(negedge clk);
    check("R6 in gap", cmd_req, 0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    check("R11 busy", busy, 0);
    check("R11 done", xfer_done, 1);
    clear_flag();
    check("R9 clear idle", match_flag, 0);

    // randomized compare checks, R3 R4 R5 R7
    cfg_interval = 16'd0; cfg_auto_stop = 1;
    for (int it = 0; it < 60; it++) begin
      logic [31:0] d;
      bit h;
      cfg_mask = $urandom; cfg_match = $urandom;
      if ($urandom % 3 == 0) cfg_mask = cfg_mask & 32'h0000_0101;
      cfg_size = 2'($urandom); cfg_or_mode = 1'($urandom);
      d = ($urandom % 2) ? ((cfg_match & cfg_mask) | ($urandom & ~cfg_mask)) : $urandom;
      if (cfg_or_mode && ($urandom % 2)) d = ~cfg_match;
      h = exp_hit(d, cfg_mask, cfg_match, cfg_size, cfg_or_mode);
      clear_flag();
      pulse_start();
      do_read(d, $urandom % 3, 0);
      check(cfg_or_mode ? "R5 rand flag" : "R4 rand flag", match_flag, h);
      check("R3 rand status", status_value, d & size_bits(cfg_size));
      check("R7 rand busy", busy, !h);
      if (!h) begin
        while (!cmd_req) @(negedge clk);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        do_read(d, 0, 0);
        check("R12 rand idle", busy, 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule